// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped controller that lets software read and write registers inside external Ethernet PHYs over the two-wire management bus. Software sees six 32-bit words on a simple write-strobe register bus with a combinational read port. It chooses a PHY and a register through an address word, then starts a frame. A write frame starts when the write-data word is written. A read frame starts when the read-request bit in the command word goes from 0 to 1. The block shifts out a 64-bit Clause 22 frame: 32 preamble ones, start 01, opcode, PHY address, register number, turnaround and 16 data bits. For a read it releases the data line at the turnaround and captures 16 bits from the PHY.

The management clock MDC is derived from the system clock by a programmable divider. Output bits change on the falling MDC edge and input bits are sampled on the rising edge. The indication word reports busy and read-not-valid. A reset bit in the configuration word aborts any frame and holds the engine idle for as long as it stays set.

Word map, by word index on `bus_addr`: 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indication. Unmapped indexes read as zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every word reads zero, MDC is low and the data line is not driven (`mdio_oe` = 0).
- R2: The address word keeps the PHY address in bits 12:8 and the register number in bits 4:0. The configuration word keeps bit 31 and the divider select in bits 2:0. The command word keeps bit 0. All other bits read as zero.
- R3: Writing word 3 while idle starts a write frame to the current address. The frame is 32 ones, then 01, opcode 01, PHY address and register number MSB first, turnaround 10 and the 16 data bits from write-data bits 15:0. All 64 bits are driven.
- R4: A read frame starts only when a write to word 1 changes bit 0 from 0 to 1. Writing 1 when the bit already holds 1 starts nothing.
- R5: A read frame drives 32 ones, 01, opcode 10, PHY address and register number, then releases the line for the turnaround and the 16 data bits. The 16 bits sampled from `mdio_i` appear MSB first in read-data bits 15:0.
- R6: Indication bit 0 (busy) is set from the cycle after a frame is started until the frame has completed, which takes exactly 64 MDC periods. While idle, MDC stays low and the line is released.
- R7: Indication bit 2 (not-valid) is set together with busy when a read starts and is cleared in the cycle the read result is loaded into the read-data word. It is never set while busy is clear.
- R8: Writing configuration bit 31 as 1 aborts any frame. In the next cycle busy and not-valid are clear, MDC is low and the line is released. While the bit stays set, start requests are ignored.
- R9: One MDC half period is (select + 1) × 2 system clocks, where select is configuration bits 2:0.
- R10: `mdio_o` and `mdio_oe` change only together with a falling MDC edge, never on a rising edge.
- R11: A write to word 3, or a 0-to-1 change of command bit 0, that arrives while busy is set starts no frame. The frame in progress completes unchanged.
- R12: A register write shows on the read port one cycle after the strobe and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Word index for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | Data line value from the pad |
| mdio_o | output | 1 | Data line value to the pad |
| mdio_oe | output | 1 | Pad output enable for the data line |

## Verification
The hardest cases are the ones that depend on events arriving in the middle of a frame. One is a soft reset that lands while MDC is high. Another is a new request, of either kind, that arrives while a frame is still shifting. The stimulus starts a slow frame and issues the reset or the competing writes after a chosen number of cycles. It then checks the pins in the very next cycle, and after completion it checks the exact 64-edge frame that a bench PHY model recorded. The refused-read case leaves command bit 0 set after a completed read. It then writes 1 again, so the rising-edge rule is tested apart from the busy rule.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int IDX_W       = 3;
    localparam int SEL_W       = 3;
    localparam int FIELD_W     = 5;
    localparam int DATA_W      = 16;
    localparam int FRAME_LEN   = 64;
    localparam int PRE_LEN     = 32;
    localparam int RD_DRIVE    = PRE_LEN + 4 + 2 * FIELD_W;
    localparam int DATA_FIRST  = FRAME_LEN - DATA_W;

    localparam logic [IDX_W-1:0] W_CFG = 3'd0;
    localparam logic [IDX_W-1:0] W_CMD = 3'd1;
    localparam logic [IDX_W-1:0] W_ADR = 3'd2;
    localparam logic [IDX_W-1:0] W_WRD = 3'd3;
    localparam logic [IDX_W-1:0] W_RDD = 3'd4;
    localparam logic [IDX_W-1:0] W_IND = 3'd5;

    typedef enum logic {SQ_IDLE, SQ_SHIFT} seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
        logic [DATA_W-1:0]  wdata;
    } mdio_req_t;

    function automatic logic [FRAME_LEN-1:0] frame_bits(input mdio_req_t r);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] body;
        op   = r.rd ? 2'b10 : 2'b01;
        ta   = r.rd ? 2'b00 : 2'b10;
        body = r.rd ? '0 : r.wdata;
        return {{PRE_LEN{1'b1}}, 2'b01, op, r.phy, r.regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    localparam int CNT_W = SEL_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             tick;

    assign half_m1 = ((CNT_W'(sel) + CNT_W'(1)) << 1) - CNT_W'(1);
    assign tick    = run && (cnt == half_m1);
    assign rise    = tick && !mdc;
    assign fall    = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              is_rd,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BIT_W = $clog2(FRAME_LEN);

    seq_state_e           state;
    logic [FRAME_LEN-1:0] shreg;
    logic [BIT_W-1:0]     bit_idx;
    logic                 last_bit;

    assign busy     = (state == SQ_SHIFT);
    assign last_bit = (bit_idx == BIT_W'(FRAME_LEN - 1));
    assign done     = busy && fall && last_bit;
    assign mdio_o   = shreg[FRAME_LEN-1];
    assign mdio_oe  = busy && (!is_rd || (bit_idx < BIT_W'(RD_DRIVE)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            is_rd   <= 1'b0;
            rd_data <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state   <= SQ_SHIFT;
                        shreg   <= frame_bits(req);
                        bit_idx <= '0;
                        is_rd   <= req.rd;
                    end
                end
                SQ_SHIFT: begin
                    if (rise && is_rd && (bit_idx >= BIT_W'(DATA_FIRST)))
                        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
                    if (fall) begin
                        if (last_bit) begin
                            state <= SQ_IDLE;
                            shreg <= '0;
                        end else begin
                            bit_idx <= bit_idx + BIT_W'(1);
                            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic               cfg_rst_q;
    logic [SEL_W-1:0]   cfg_sel_q;
    logic               cmd_q;
    logic [FIELD_W-1:0] adr_phy_q;
    logic [FIELD_W-1:0] adr_reg_q;
    logic [DATA_W-1:0]  wrd_q;
    logic [DATA_W-1:0]  rdd_q;
    logic               nv_q;

    logic wr_cfg, wr_cmd, wr_adr, wr_wrd;
    logic soft_now, eng_rst;
    logic wr_go, rd_go, start;
    logic seq_busy, seq_done, seq_rd;
    logic mdc_rise, mdc_fall;
    logic [DATA_W-1:0] seq_rdata;
    mdio_req_t req;

    assign wr_cfg = bus_wr && (bus_addr == W_CFG);
    assign wr_cmd = bus_wr && (bus_addr == W_CMD);
    assign wr_adr = bus_wr && (bus_addr == W_ADR);
    assign wr_wrd = bus_wr && (bus_addr == W_WRD);

    assign soft_now = cfg_rst_q || (wr_cfg && bus_wdata[31]);
    assign eng_rst  = rst || soft_now;

    assign wr_go = wr_wrd && !seq_busy && !soft_now;
    assign rd_go = wr_cmd && bus_wdata[0] && !cmd_q && !seq_busy && !soft_now;
    assign start = wr_go || rd_go;

    assign req.rd    = rd_go;
    assign req.phy   = adr_phy_q;
    assign req.regn  = adr_reg_q;
    assign req.wdata = bus_wdata[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rst_q <= 1'b0;
            cfg_sel_q <= '0;
            cmd_q     <= 1'b0;
            adr_phy_q <= '0;
            adr_reg_q <= '0;
            wrd_q     <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_rst_q <= bus_wdata[31];
                cfg_sel_q <= bus_wdata[SEL_W-1:0];
            end
            if (wr_cmd) cmd_q <= bus_wdata[0];
            if (wr_adr) begin
                adr_phy_q <= bus_wdata[8 +: FIELD_W];
                adr_reg_q <= bus_wdata[0 +: FIELD_W];
            end
            if (wr_wrd) wrd_q <= bus_wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdd_q <= '0;
        end else if (seq_done && seq_rd) begin
            rdd_q <= seq_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (eng_rst) begin
            nv_q <= 1'b0;
        end else if (rd_go) begin
            nv_q <= 1'b1;
        end else if (seq_done && seq_rd) begin
            nv_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            W_CFG:   bus_rdata = {cfg_rst_q, {(31-SEL_W){1'b0}}, cfg_sel_q};
            W_CMD:   bus_rdata = {31'b0, cmd_q};
            W_ADR:   bus_rdata = {19'b0, adr_phy_q, 3'b0, adr_reg_q};
            W_WRD:   bus_rdata = {16'b0, wrd_q};
            W_RDD:   bus_rdata = {16'b0, rdd_q};
            W_IND:   bus_rdata = {29'b0, nv_q, 1'b0, seq_busy};
            default: bus_rdata = '0;
        endcase
    end

    mdio_clk_gen #(.SEL_W(SEL_W)) u_clk (
        .clk  (clk),
        .rst  (eng_rst),
        .run  (seq_busy),
        .sel  (cfg_sel_q),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (eng_rst),
        .start   (start),
        .req     (req),
        .rise    (mdc_rise),
        .fall    (mdc_fall),
        .mdio_i  (mdio_i),
        .busy    (seq_busy),
        .done    (seq_done),
        .is_rd   (seq_rd),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (seq_rdata)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic clk,
    input logic rst,
    input logic bus_wr,
    input logic busy,
    input logic nv,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic soft_hold
);
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdio_oe && !mdc));

    // R7
    nv_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        nv |-> busy);

    // R8
    soft_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        soft_hold |-> !busy);

    // R10
    no_change_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R12
    start_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_wr));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .busy      (seq_busy),
    .nv        (nv_q),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .soft_hold (cfg_rst_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    // bench PHY model
    int          rcount = 0;
    logic [63:0] cap_o;
    logic [63:0] cap_oe;
    longint      t_r0, t_r1;
    logic [15:0] phy_data = '0;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(posedge mdc) begin
        if (rcount < 64) begin
            cap_o[rcount]  = mdio_o;
            cap_oe[rcount] = mdio_oe;
        end
        if (rcount == 0) t_r0 = $time;
        if (rcount == 1) t_r1 = $time;
        rcount = rcount + 1;
    end

    always @(negedge mdc) begin
        if (rcount >= 48 && rcount < 64) mdio_i = phy_data[63 - rcount];
        else mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(3'd5, v);
            if (v[0] == 1'b0) return;
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit r, input logic [4:0] p,
                                               input logic [4:0] g, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b10, d};
    endfunction

    function automatic int frame_mismatch(input bit r, input logic [63:0] e);
        int m = 0;
        for (int i = 0; i < 64; i++) begin
            bit e_oe = !r || (i < 46);
            if (cap_oe[i] !== e_oe) m++;
            else if (e_oe && cap_o[i] !== e[63 - i]) m++;
        end
        return m;
    endfunction

    task automatic xfer(input bit r, input logic [4:0] p, input logic [4:0] g,
                        input logic [15:0] d, input logic [2:0] sel);
        logic [31:0] v;
        longint half;
        wr(3'd0, {29'b0, sel});
        wr(3'd2, {19'b0, p, 3'b0, g});
        rcount = 0;
        phy_data = d;
        if (r) begin
            wr(3'd1, 32'd0);
            wr(3'd1, 32'd1);
        end else begin
            wr(3'd3, {16'b0, d});
        end
        rd(3'd5, v);
        // R6 busy and R7 not-valid one cycle after the start strobe
        chk(v == (r ? 32'd5 : 32'd1), r ? "R7 indication after read start" : "R6 busy after write start",
            v, r ? 5 : 1);
        wait_idle();
        chk(rcount == 64, "R6 frame has 64 MDC periods", rcount, 64);
        chk(frame_mismatch(r, exp_frame(r, p, g, d)) == 0,
            r ? "R5 read frame bits" : "R3 write frame bits",
            frame_mismatch(r, exp_frame(r, p, g, d)), 0);
        half = longint'((sel + 1) * 2 * CLK_PERIOD);
        chk((t_r1 - t_r0) == 2 * half, "R9 MDC period", t_r1 - t_r0, 2 * half);
        rd(3'd5, v);
        chk(v == 32'd0, "R7 indication clear after frame", v, 0);
        if (r) begin
            rd(3'd4, v);
            chk(v == {16'b0, d}, "R5 read data captured", v, {16'b0, d});
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [63:0] first;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            chk(v == 32'd0, "R1 word zero after reset", v, 0);
        end
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle after reset", {mdc, mdio_oe}, 0);

        // R12 write not visible before the edge, visible one cycle after
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'hFFFF_FFFF;
        #1;
        chk(bus_rdata == 32'd0, "R12 not visible before edge", bus_rdata, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3'd2, v);
        // R2 address fields 12:8 and 4:0
        chk(v == 32'h0000_1F1F, "R2 address readback mask", v, 32'h1F1F);
        wr(3'd1, 32'hFFFF_FFFE);
        rd(3'd1, v);
        chk(v == 32'd0, "R2 command mask", v, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v);
        chk(v == 32'h8000_0007, "R2 configuration mask", v, 32'h8000_0007);
        wr(3'd0, 32'd0);

        // directed: slowest divider write, then read
        xfer(1'b0, 5'h15, 5'h0A, 16'hA5C3, 3'd7);
        xfer(1'b1, 5'h01, 5'h1F, 16'h8001, 3'd0);

        // R4 repeated 1 while bit already 1 starts nothing
        rcount = 0;
        wr(3'd1, 32'd1);
        repeat (20) @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'd0 && rcount == 0, "R4 no read without 0-to-1", v, 0);

        // R11 requests during a frame are ignored
        wr(3'd0, 32'd0);
        wr(3'd2, {19'b0, 5'h03, 3'b0, 5'h04});
        rcount = 0;
        wr(3'd3, 32'h0000_1357);
        wr(3'd3, 32'h0000_FFFF);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        rd(3'd5, v);
        chk(v == 32'd1, "R11 no read flag while busy", v, 1);
        wait_idle();
        first = exp_frame(1'b0, 5'h03, 5'h04, 16'h1357);
        chk(rcount == 64 && frame_mismatch(1'b0, first) == 0, "R11 frame in progress unchanged",
            frame_mismatch(1'b0, first), 0);
        repeat (10) @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'd0, "R11 nothing queued", v, 0);

        // R8 soft reset aborts mid-frame, then holds
        wr(3'd0, 32'd3);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        repeat (37) @(negedge clk);
        wr(3'h0, 32'h8000_0003);
        rd(3'd5, v);
        chk(v == 32'd0, "R8 flags clear after abort", v, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 pins idle after abort", {mdc, mdio_oe}, 0);
        wr(3'd3, 32'h0000_2222);
        rd(3'd5, v);
        chk(v == 32'd0, "R8 start ignored while held", v, 0);
        wr(3'd0, 32'd0);

        // constrained random transactions
        for (int n = 0; n < 8; n++) begin
            bit          r = 1'($urandom_range(0, 1));
            logic [4:0]  p = 5'($urandom_range(0, 31));
            logic [4:0]  g = 5'($urandom_range(0, 31));
            logic [15:0] d = 16'($urandom_range(0, 65535));
            logic [2:0]  s = 3'($urandom_range(0, 3));
            xfer(r, p, g, d, s);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule